// File: doc/BRIEF.md
# Power-of-Two Peripheral Bus Prescaler

This block turns a fast system clock into a slower peripheral-bus timing reference. It does not gate or generate a new clock tree. It produces a one-cycle clock-enable pulse that peripheral logic qualifies its registers with. It also produces a square divided-clock signal for observation or low-speed use. The ratio is chosen by a 3-bit code that selects divide-by-1, 2, 4, 8 or 16. Half of the code space (every code with the top bit clear) means no division.

A code presented with the write strobe is not applied at once. It is parked as a pending request and moved into the active ratio only at the edge that closes the current divided period. The output pattern therefore never shows a truncated period. The switch lands between 1 and 16 system cycles after the write. A status output shows that a request is parked and not yet in force. If software writes again before the switch, the newer code replaces the parked one.

Top module: `bus_prescaler`

## Requirements
- R1: While reset is high and in the first cycle after it, the active ratio is divide-by-1, the period counter is 0, `bus_en` and `bus_clk` are 1, and `cfg_pending` is 0.
- R2: Any code with bit 2 equal to 0 (000, 001, 010, 011) selects divide-by-1. Once it is active, `bus_en` is 1 in every cycle.
- R3: Codes 100, 101, 110 and 111 select divide-by 2, 4, 8 and 16. Once the code is active, `bus_en` is a single-cycle pulse in the first cycle of every period of that many system cycles.
- R4: For ratios of 2 and above, `bus_clk` is 1 for the first half of each period and 0 for the second half. At divide-by-1, `bus_clk` stays 1.
- R5: A written code becomes active only at the clock edge that ends the current divided period. The following period is the first one at the new ratio. The delay from the write edge to the switch edge is 1 to 16 cycles and never zero.
- R6: When several writes arrive before the switch, only the code of the most recent write is applied.
- R7: `cfg_pending` is 1 from the cycle after a write until the edge at which the parked code becomes active, and 0 otherwise.
- R8: A write in the last cycle of a period does not switch at that edge. It waits for the end of the next full period at the old ratio, which gives 16 cycles at divide-by-16 and 1 cycle at divide-by-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_code | input | 3 | Prescaler code, sampled when `cfg_wr` is 1 |
| cfg_wr | input | 1 | Write strobe for `cfg_code` |
| bus_en | output | 1 | One-cycle enable at the start of each divided period |
| bus_clk | output | 1 | Divided clock, high for the first half of each period |
| cfg_pending | output | 1 | A written code is parked and not yet active |

## Verification
All four pass-through codes are written and must give an enable on every cycle. This separates the don't-care group from the dividing codes. Each dividing code is then run for a fixed 64-cycle window, and the enable and high-clock counts identify the exact ratio and duty. Writes are placed at counter offsets 0, 5, 14 and 15 of a divide-by-16 period, and the measured delay tells a switch on period end apart from an immediate switch or a lost write. A burst of three back-to-back writes shows whether the last or an earlier code wins.

// File: rtl/bpre_pkg.sv
package bpre_pkg;
  // code field: top bit selects dividing group, low bits select the power
  localparam int CODE_W   = 3;
  localparam int MAX_SHIFT = 2 ** (CODE_W - 1);
  localparam int SHIFT_W  = $clog2(MAX_SHIFT + 1);
  localparam int CNT_W    = MAX_SHIFT;

  typedef logic [SHIFT_W-1:0] shift_t;

  typedef struct packed {
    logic   vld;
    shift_t shift;
  } req_t;
endpackage

// File: rtl/bpre_decode.sv
module bpre_decode #(
  parameter int CODE_W  = bpre_pkg::CODE_W,
  parameter int SHIFT_W = bpre_pkg::SHIFT_W
) (
  input  logic [CODE_W-1:0]  code,
  output logic [SHIFT_W-1:0] shift
);
  localparam int LOW_W = CODE_W - 1;

  // top bit clear: pass-through group, ratio 1
  always_comb begin
    if (code[CODE_W-1])
      shift = SHIFT_W'(code[LOW_W-1:0]) + SHIFT_W'(1);
    else
      shift = '0;
  end
endmodule

// File: rtl/bpre_hold.sv
module bpre_hold #(
  parameter int SHIFT_W = bpre_pkg::SHIFT_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr,
  input  logic [SHIFT_W-1:0] wr_shift,
  input  logic               wrap,
  output logic [SHIFT_W-1:0] act_q,
  output logic [SHIFT_W-1:0] act_n,
  output logic               pend_q
);
  logic [SHIFT_W-1:0] park_q;
  logic               take;

  // a write in the wrap cycle defers the switch to the next period end
  assign take  = wrap && pend_q && !wr;
  assign act_n = take ? park_q : act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= '0;
      park_q <= '0;
      pend_q <= 1'b0;
    end else begin
      act_q <= act_n;
      if (wr) begin
        park_q <= wr_shift;
        pend_q <= 1'b1;
      end else if (take) begin
        pend_q <= 1'b0;
      end
    end
  end

  assert_switch_on_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable(act_q) |-> $past(wrap));

  assert_no_switch_on_write_R8: assert property (@(posedge clk) disable iff (rst)
    $past(wr) |-> $stable(act_q));

  assert_write_sets_pending_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr)) |-> pend_q);
endmodule

// File: rtl/bpre_count.sv
module bpre_count #(
  parameter int SHIFT_W = bpre_pkg::SHIFT_W,
  parameter int CNT_W   = bpre_pkg::CNT_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [SHIFT_W-1:0] shift_q,
  input  logic [SHIFT_W-1:0] shift_n,
  output logic               wrap,
  output logic               en_q,
  output logic               dclk_q
);
  localparam logic [CNT_W-1:0] ONES = '1;

  logic [CNT_W-1:0] cnt_q, cnt_n, last, half_n;
  logic             dclk_n;

  assign last = ONES >> (SHIFT_W'(CNT_W) - shift_q);
  assign wrap = (cnt_q == last);
  assign cnt_n = wrap ? '0 : cnt_q + CNT_W'(1);

  always_comb begin
    half_n = '0;
    dclk_n = 1'b1;
    if (shift_n != '0) begin
      half_n = CNT_W'(1) << (shift_n - SHIFT_W'(1));
      dclk_n = (cnt_n < half_n);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      en_q   <= 1'b1;
      dclk_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_n;
      en_q   <= (cnt_n == '0);
      dclk_q <= dclk_n;
    end
  end

  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    (en_q && shift_q != '0) |=> !en_q);

  assert_clk_high_at_start_R4: assert property (@(posedge clk) disable iff (rst)
    en_q |-> dclk_q);
endmodule

// File: rtl/bus_prescaler.sv
module bus_prescaler #(
  parameter int CODE_W  = bpre_pkg::CODE_W,
  parameter int SHIFT_W = bpre_pkg::SHIFT_W,
  parameter int CNT_W   = bpre_pkg::CNT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] cfg_code,
  input  logic              cfg_wr,
  output logic              bus_en,
  output logic              bus_clk,
  output logic              cfg_pending
);
  logic [SHIFT_W-1:0] wr_shift, act_q, act_n;
  logic               wrap;

  bpre_decode #(.CODE_W(CODE_W), .SHIFT_W(SHIFT_W)) u_dec (
    .code  (cfg_code),
    .shift (wr_shift)
  );

  bpre_hold #(.SHIFT_W(SHIFT_W)) u_hold (
    .clk      (clk),
    .rst      (rst),
    .wr       (cfg_wr),
    .wr_shift (wr_shift),
    .wrap     (wrap),
    .act_q    (act_q),
    .act_n    (act_n),
    .pend_q   (cfg_pending)
  );

  bpre_count #(.SHIFT_W(SHIFT_W), .CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .shift_q (act_q),
    .shift_n (act_n),
    .wrap    (wrap),
    .en_q    (bus_en),
    .dclk_q  (bus_clk)
  );

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (bus_en && bus_clk && !cfg_pending));

  assert_bypass_every_cycle_R2: assert property (@(posedge clk) disable iff (rst)
    (act_q == '0 && !cfg_pending) |-> bus_en);
endmodule

// File: tb/bus_prescaler_tb.sv
module bus_prescaler_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] cfg_code = 3'b000;
  logic       cfg_wr = 1'b0;
  logic       bus_en, bus_clk, cfg_pending;

  int n_chk = 0;
  int n_bad = 0;

  // reference state, built from the requirements
  int m_shift, m_cnt, m_pshift;
  bit m_pend;
  bit s_en, s_clk, s_pend;

  always #5 clk = ~clk;

  bus_prescaler u_dut (
    .clk(clk), .rst(rst), .cfg_code(cfg_code), .cfg_wr(cfg_wr),
    .bus_en(bus_en), .bus_clk(bus_clk), .cfg_pending(cfg_pending)
  );

  function automatic int code_shift(input logic [2:0] c);
    return c[2] ? int'(c[1:0]) + 1 : 0;
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // one cycle: sample and compare at negedge, drive, then advance model at posedge
  task automatic step(input string tag, input logic [2:0] code, input bit wr);
    int exp_clk;
    bit wrapm;
    @(negedge clk);
    s_en = bus_en; s_clk = bus_clk; s_pend = cfg_pending;
    exp_clk = (m_shift == 0) ? 1 : int'(m_cnt < (1 << (m_shift - 1)));
    if (!rst) begin
      check(tag, "bus_en", int'(s_en), int'(m_cnt == 0));
      check(tag, "bus_clk", int'(s_clk), exp_clk);
      check(tag, "cfg_pending", int'(s_pend), int'(m_pend));
    end
    cfg_code = code;
    cfg_wr = wr;
    @(posedge clk);
    if (rst) begin
      m_shift = 0; m_cnt = 0; m_pend = 0; m_pshift = 0;
    end else begin
      wrapm = (m_cnt == (1 << m_shift) - 1);
      m_cnt = wrapm ? 0 : m_cnt + 1;
      if (wr) begin
        m_pend = 1; m_pshift = code_shift(code);
      end else if (wrapm && m_pend) begin
        m_shift = m_pshift; m_pend = 0;
      end
    end
  endtask

  task automatic idle(input string tag, input int n);
    for (int i = 0; i < n; i++) step(tag, cfg_code, 1'b0);
  endtask

  // write and return measured delay until pending clears
  task automatic write_measure(input string tag, input logic [2:0] code, output int lat);
    int k;
    step(tag, code, 1'b1);
    k = 0;
    do begin
      step(tag, code, 1'b0);
      k++;
    end while (s_pend && k < 40);
    lat = k - 1;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    idle("R1", 3);
    @(negedge clk);
    check("R1", "bus_en in reset", int'(bus_en), 1);
    check("R1", "bus_clk in reset", int'(bus_clk), 1);
    check("R1", "pending in reset", int'(cfg_pending), 0);
    rst = 1'b0;
    idle("R1", 1);
    check("R1", "bus_en after reset", int'(s_en), 1);
    check("R1", "pending after reset", int'(s_pend), 0);
  endtask

  // R2: every pass-through code gives an enable each cycle
  task automatic t_bypass();
    int lat, ens;
    for (int c = 0; c < 4; c++) begin
      write_measure("R2", 3'(c), lat);
      check("R8", "div1 switch delay", lat, 1);
      ens = 0;
      for (int i = 0; i < 16; i++) begin
        step("R2", 3'(c), 1'b0);
        ens += int'(s_en);
      end
      check("R2", "enables in 16 cycles", ens, 16);
    end
  endtask

  // R3/R4: pulse count and high-time count over a 64-cycle window
  task automatic t_ratios();
    int lat, ens, his, n;
    for (int c = 4; c < 8; c++) begin
      write_measure("R3", 3'(c), lat);
      n = 1 << (c - 3);
      ens = 0; his = 0;
      for (int i = 0; i < 64; i++) begin
        step("R3", 3'(c), 1'b0);
        ens += int'(s_en);
        his += int'(s_clk);
      end
      check("R3", $sformatf("enables at div%0d", n), ens, 64 / n);
      check("R4", $sformatf("high cycles at div%0d", n), his, 32);
    end
  endtask

  // R5/R7/R8: write at chosen offsets of a div16 period
  task automatic t_latency();
    int lat, offs[4];
    offs = '{0, 5, 14, 15};
    for (int j = 0; j < 4; j++) begin
      while (m_cnt != offs[j]) step("R5", 3'b111, 1'b0);
      write_measure("R5", 3'b111, lat);
      check(offs[j] == 15 ? "R8" : "R5",
            $sformatf("delay from offset %0d", offs[j]), lat,
            offs[j] == 15 ? 16 : 15 - offs[j]);
      check("R7", "pending clear after switch", int'(s_pend), 0);
    end
  endtask

  // R6: back-to-back writes, the last one wins
  task automatic t_multi();
    int ens;
    while (m_cnt != 3) step("R6", 3'b111, 1'b0);
    step("R6", 3'b110, 1'b1);
    step("R6", 3'b100, 1'b1);
    step("R6", 3'b101, 1'b1);
    step("R7", 3'b101, 1'b0);
    check("R7", "pending after burst", int'(s_pend), 1);
    idle("R6", 20);
    ens = 0;
    for (int i = 0; i < 64; i++) begin
      step("R6", 3'b101, 1'b0);
      ens += int'(s_en);
    end
    check("R6", "enables at last code div4", ens, 16);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_bypass();
    t_ratios();
    t_latency();
    t_multi();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule